// File: doc/BRIEF.md
# Free-Fall and Wake-Up Interrupt Engine

This block watches a stream of three-axis signed acceleration samples. It raises an interrupt when the motion pattern matches a programmed condition. Each axis sample is converted to a magnitude and compared with a single programmable threshold. The comparison gives one "high" event (magnitude above the threshold) and one "low" event (magnitude at or below it) per axis. A six-bit enable mask selects which of these events take part.

The enabled events are then merged. In OR mode the condition is true when any enabled event is true, which suits wake-up detection. In AND mode the condition is true only when every enabled event is true, which suits free-fall detection (all axes near zero). The merged condition must hold for more than a programmed number of consecutive samples before it qualifies. Only qualified samples reach the source flags and the interrupt line.

The source flags can run in two ways. In live mode they follow the latest sample. In latching mode they accumulate until a read strobe clears them. The surrounding logic drives one strobe per output-data period on `sample_valid`. That strobe sets the time base for the duration count.

Top module: `fwu_irq_engine`

## Requirements
- R1: For each axis the magnitude of the two's-complement sample is computed, and the sample's most negative code maps to its full positive size. The high event is true when magnitude > threshold and the low event is true when magnitude <= threshold.
- R2: Event bit positions in `event_mask` and `src_flags` are fixed: bit 0 X-low, bit 1 X-high, bit 2 Y-low, bit 3 Y-high, bit 4 Z-low, bit 5 Z-high. An event whose mask bit is 0 never appears in `src_flags` and never contributes to the condition.
- R3: With `and_mode`=1 the condition is true only when the mask is non-zero and every enabled event is true.
- R4: With `and_mode`=0 the condition is true when at least one enabled event is true.
- R5: `src_active` is 1 exactly when at least one `src_flags` bit is 1, and `irq` equals `src_active`.
- R6: A sample qualifies when the condition has been true on more than `duration` consecutive samples, the current one included. With `duration`=0 the first true sample qualifies. A sample with a false condition restarts the count.
- R7: With `latch_en`=0, each sample loads `src_flags` with the enabled events of a qualifying sample, or with zero otherwise. `src_rd` has no effect.
- R8: With `latch_en`=1, a qualifying sample ORs its enabled events into `src_flags`. Non-qualifying samples leave the flags unchanged.
- R9: With `latch_en`=1, `src_rd` clears `src_flags` one cycle later. The events of a qualifying sample taken in the same cycle as the read are kept.
- R10: After reset the flags, `src_active`, `irq` and the duration count are all zero.
- R11: Outputs change only in the cycle after a `sample_valid` or a latched-mode read. Cycles without `sample_valid` neither advance nor reset the duration count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_valid | input | 1 | One-cycle strobe marking a new sample set |
| x_smp | input | AXIS_W | X-axis sample, two's complement |
| y_smp | input | AXIS_W | Y-axis sample, two's complement |
| z_smp | input | AXIS_W | Z-axis sample, two's complement |
| threshold | input | AXIS_W | Unsigned magnitude threshold |
| event_mask | input | 6 | Event enables, bit order as in R2 |
| and_mode | input | 1 | 1: AND of enabled events, 0: OR |
| latch_en | input | 1 | 1: flags accumulate until read |
| duration | input | DUR_W | Required number of consecutive true samples, minus one |
| src_rd | input | 1 | Read strobe for the source flags |
| src_flags | output | 6 | Reported events, bit order as in R2 |
| src_active | output | 1 | At least one flag is set |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps every sample code on each axis against thresholds on both sides of each magnitude. A comparator that takes the most negative code as negative, or that treats equality as high, would then report the wrong event. It checks AND mode with an empty mask, which a naive all-true reduction would fire on. It checks a duration window that is broken one sample before completion and then restarted; a counter that does not clear would fire early. It also checks a read that coincides with a qualifying sample, idle cycles between samples, and a read in live mode. A design that lets a read win over a new event, counts clocks rather than samples, or lets a read touch live flags would show up in these checks.

// File: rtl/fwu_pkg.sv
package fwu_pkg;
   localparam int unsigned NAX    = 3;
   localparam int unsigned NEV    = 2 * NAX;
   localparam int unsigned LO_OFS = 0;
   localparam int unsigned HI_OFS = 1;
   typedef logic [NEV-1:0] evvec_t;
endpackage

// File: rtl/fwu_axis_cmp.sv
module fwu_axis_cmp #(
   parameter int unsigned AXIS_W = 8
) (
   input  logic [AXIS_W-1:0] smp,
   input  logic [AXIS_W-1:0] thr,
   output logic              ev_hi,
   output logic              ev_lo
);
   logic [AXIS_W-1:0] mag;

   // The most negative code negates to itself, which read unsigned is its true magnitude.
   always_comb begin
      mag   = smp[AXIS_W-1] ? (~smp + 1'b1) : smp;
      ev_hi = (mag > thr);
      ev_lo = !ev_hi;
   end
endmodule

// File: rtl/fwu_combine.sv
module fwu_combine
   import fwu_pkg::*;
(
   input  evvec_t ev,
   input  evvec_t mask,
   input  logic   and_mode,
   output evvec_t ev_masked,
   output logic   cond
);
   always_comb begin
      ev_masked = ev & mask;
      if (and_mode) cond = (|mask) && (&(ev | ~mask));
      else          cond = |ev_masked;
   end
endmodule

// File: rtl/fwu_run_ctr.sv
module fwu_run_ctr #(
   parameter int unsigned DUR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sample_valid,
   input  logic             cond,
   input  logic [DUR_W-1:0] duration,
   output logic             qual
);
   localparam int unsigned CW = DUR_W + 1;
   localparam logic [CW-1:0] CMAX = {CW{1'b1}};

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] run_now;

   always_comb begin
      if (!cond)              run_now = '0;
      else if (cnt_q == CMAX) run_now = cnt_q;
      else                    run_now = cnt_q + 1'b1;
      qual = sample_valid && cond && (run_now > {1'b0, duration});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (sample_valid) cnt_q <= run_now;
   end

   AST_RUN_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      sample_valid && !cond |=> cnt_q == '0);                        // R6
   AST_CNT_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_valid |=> $stable(cnt_q));                              // R11
endmodule

// File: rtl/fwu_src_reg.sv
module fwu_src_reg
   import fwu_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   latch_en,
   input  logic   sample_valid,
   input  logic   qual,
   input  evvec_t ev_masked,
   input  logic   rd,
   output evvec_t flags,
   output logic   active
);
   evvec_t flags_q, flags_nxt;
   logic   active_q;

   always_comb begin
      flags_nxt = flags_q;
      if (latch_en) begin
         if (rd)   flags_nxt = '0;
         if (qual) flags_nxt = flags_nxt | ev_masked;
      end else if (sample_valid) begin
         flags_nxt = qual ? ev_masked : '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q  <= '0;
         active_q <= 1'b0;
      end else begin
         flags_q  <= flags_nxt;
         active_q <= |flags_nxt;
      end
   end

   assign flags  = flags_q;
   assign active = active_q;

   AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      latch_en && !rd |=> (flags_q & $past(flags_q)) == $past(flags_q)); // R8
   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      latch_en && rd && !sample_valid |=> flags_q == '0);              // R9
   AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_valid && !(latch_en && rd) |=> $stable(flags_q));         // R11
endmodule

// File: rtl/fwu_irq_engine.sv
module fwu_irq_engine
   import fwu_pkg::*;
#(
   parameter int unsigned AXIS_W = 8,
   parameter int unsigned DUR_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample_valid,
   input  logic [AXIS_W-1:0] x_smp,
   input  logic [AXIS_W-1:0] y_smp,
   input  logic [AXIS_W-1:0] z_smp,
   input  logic [AXIS_W-1:0] threshold,
   input  logic [5:0]        event_mask,
   input  logic              and_mode,
   input  logic              latch_en,
   input  logic [DUR_W-1:0]  duration,
   input  logic              src_rd,
   output logic [5:0]        src_flags,
   output logic              src_active,
   output logic              irq
);
   initial begin
      assert (AXIS_W >= 2 && AXIS_W <= 32) else $error("AXIS_W out of range");
      assert (DUR_W >= 1 && DUR_W <= 16) else $error("DUR_W out of range");
      assert (NEV == 6) else $error("event vector must be six bits");
   end

   logic [AXIS_W-1:0] smp [NAX];
   evvec_t ev, ev_masked;
   logic   cond, qual;

   assign smp[0] = x_smp;
   assign smp[1] = y_smp;
   assign smp[2] = z_smp;

   for (genvar a = 0; a < NAX; a++) begin : g_axis
      fwu_axis_cmp #(.AXIS_W(AXIS_W)) i_cmp (
         .smp   (smp[a]),
         .thr   (threshold),
         .ev_hi (ev[2*a+HI_OFS]),
         .ev_lo (ev[2*a+LO_OFS])
      );
   end

   fwu_combine i_comb (
      .ev        (ev),
      .mask      (event_mask),
      .and_mode  (and_mode),
      .ev_masked (ev_masked),
      .cond      (cond)
   );

   fwu_run_ctr #(.DUR_W(DUR_W)) i_run (
      .clk          (clk),
      .rst_n        (rst_n),
      .sample_valid (sample_valid),
      .cond         (cond),
      .duration     (duration),
      .qual         (qual)
   );

   fwu_src_reg i_src (
      .clk          (clk),
      .rst_n        (rst_n),
      .latch_en     (latch_en),
      .sample_valid (sample_valid),
      .qual         (qual),
      .ev_masked    (ev_masked),
      .rd           (src_rd),
      .flags        (src_flags),
      .active       (src_active)
   );

   assign irq = src_active;

   AST_AND_ALL_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      and_mode && cond |-> (ev_masked == event_mask) && (|event_mask)); // R3
   AST_OR_ANY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      !and_mode && cond |-> (|ev_masked));                            // R4
   AST_ACTIVE_MATCHES_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      src_active == (|src_flags));                                    // R5
   AST_QUAL_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      qual |-> sample_valid && cond);                                 // R6
endmodule

// File: tb/test_fwu_irq_engine.sv
module test_fwu_irq_engine;
   localparam int unsigned AW = 4;
   localparam int unsigned DW = 8;
   localparam int RUN_MAX = (1 << (DW + 1)) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sample_valid = 1'b0;
   logic [AW-1:0] x_smp = '0, y_smp = '0, z_smp = '0;
   logic [AW-1:0] threshold = '0;
   logic [5:0]    event_mask = '0;
   logic          and_mode = 1'b0, latch_en = 1'b0;
   logic [DW-1:0] duration = '0;
   logic          src_rd = 1'b0;
   logic [5:0]    src_flags;
   logic          src_active, irq;

   int   n_chk = 0, n_fail = 0;
   bit   done = 0;
   int   m_run = 0;
   logic [5:0] m_flags = '0;

   always #10 clk = ~clk;

   fwu_irq_engine #(.AXIS_W(AW), .DUR_W(DW)) i_fwu_irq_engine (
      .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
      .x_smp(x_smp), .y_smp(y_smp), .z_smp(z_smp),
      .threshold(threshold), .event_mask(event_mask), .and_mode(and_mode),
      .latch_en(latch_en), .duration(duration), .src_rd(src_rd),
      .src_flags(src_flags), .src_active(src_active), .irq(irq));

   function automatic int mag_of(input int v);
      return (v < 0) ? -v : v;
   endfunction

   task automatic check(input string tag);
      logic exp_act;
      exp_act = |m_flags;
      n_chk++;
      if (src_flags !== m_flags || src_active !== exp_act || irq !== exp_act) begin
         n_fail++;
         $display("FAIL %s: flags=%b active=%b irq=%b expected flags=%b active=%b irq=%b",
                  tag, src_flags, src_active, irq, m_flags, exp_act, exp_act);
      end
   endtask

   task automatic apply(input int xv, input int yv, input int zv, input bit rd, input string tag);
      int         vals [3];
      logic [5:0] ev, evm;
      bit         cond, qual;
      @(negedge clk);
      x_smp = xv[AW-1:0]; y_smp = yv[AW-1:0]; z_smp = zv[AW-1:0];
      src_rd = rd; sample_valid = 1'b1;
      vals[0] = xv; vals[1] = yv; vals[2] = zv;
      for (int a = 0; a < 3; a++) begin
         ev[2*a+1] = mag_of(vals[a]) > int'(threshold);
         ev[2*a]   = !ev[2*a+1];
      end
      evm  = ev & event_mask;
      cond = and_mode ? (event_mask != 0 && evm == event_mask) : (evm != 0);
      if (!cond) m_run = 0;
      else if (m_run < RUN_MAX) m_run++;
      qual = cond && (m_run > int'(duration));
      if (latch_en) begin
         if (rd) m_flags = '0;
         if (qual) m_flags = m_flags | evm;
      end else begin
         m_flags = qual ? evm : '0;
      end
      @(negedge clk);
      sample_valid = 1'b0; src_rd = 1'b0;
      check(tag);
   endtask

   task automatic idle(input bit rd, input string tag);
      @(negedge clk);
      src_rd = rd; sample_valid = 1'b0;
      if (latch_en && rd) m_flags = '0;
      @(negedge clk);
      src_rd = 1'b0;
      check(tag);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: run did not finish, actual hung expected done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      check("R10 during reset");
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 after reset");

      // R1: every code on every axis against thresholds around each magnitude
      event_mask = 6'b111111; and_mode = 1'b0; duration = '0; latch_en = 1'b0;
      for (int ax = 0; ax < 3; ax++)
         for (int t = 0; t <= 8; t++) begin
            threshold = t[AW-1:0];
            for (int v = -8; v <= 7; v++)
               apply(ax == 0 ? v : 0, ax == 1 ? v : 0, ax == 2 ? v : 0, 1'b0, "R1 sweep");
         end

      // R2: only X-high enabled
      threshold = 4'd3; event_mask = 6'b000010;
      apply(5, 0, 0, 1'b0, "R2 enabled event reported");
      apply(1, -7, 6, 1'b0, "R2 disabled events ignored");

      // R4: OR of highs, one axis high
      event_mask = 6'b101010;
      apply(0, -6, 0, 1'b0, "R4 single high event");
      apply(0, 0, 0, 1'b0, "R4 no enabled event");

      // R3: AND of lows (free-fall)
      and_mode = 1'b1; event_mask = 6'b010101;
      apply(1, -3, 3, 1'b0, "R3 all lows true");
      apply(1, -4, 0, 1'b0, "R3 one low false");
      event_mask = 6'b000000;
      apply(0, 0, 0, 1'b0, "R3 empty mask never fires");
      and_mode = 1'b0;

      // R6 / R11: duration window, broken run, idle cycles between samples
      event_mask = 6'b000010; duration = 8'd3;
      apply(7, 0, 0, 1'b0, "R6 run 1 of 4");
      idle(1'b0, "R11 idle does not count");
      apply(7, 0, 0, 1'b0, "R6 run 2 of 4");
      apply(7, 0, 0, 1'b0, "R6 run 3 of 4");
      apply(0, 0, 0, 1'b0, "R6 run broken");
      apply(7, 0, 0, 1'b0, "R6 restart 1");
      apply(7, 0, 0, 1'b0, "R6 restart 2");
      apply(7, 0, 0, 1'b0, "R6 restart 3");
      apply(-8, 0, 0, 1'b0, "R6 qualifies on 4th");
      apply(7, 0, 0, 1'b0, "R6 stays qualified");

      // R7 / R11: live mode ignores reads, holds between samples
      idle(1'b1, "R7 read ignored in live mode");
      x_smp = '0;
      idle(1'b0, "R11 input change without strobe");
      duration = '0;
      apply(0, 0, 0, 1'b0, "R7 live flags drop");

      // R8: latching accumulates and holds
      latch_en = 1'b1; event_mask = 6'b101010;
      apply(6, 0, 0, 1'b0, "R8 first event latched");
      apply(0, 5, 0, 1'b0, "R8 second event ORed in");
      apply(0, 0, 0, 1'b0, "R8 held over quiet sample");
      idle(1'b0, "R8 held over idle");

      // R9: read clears, coincident event survives
      idle(1'b1, "R9 read clears");
      apply(0, 5, 0, 1'b0, "R9 refill");
      apply(0, 0, -7, 1'b1, "R9 read with new event");
      apply(0, 0, 0, 1'b1, "R9 read with quiet sample");

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule